// File: doc/BRIEF.md
# Grouped Supply Rail Sequencer

This block brings three supply groups up in a fixed order and takes them down in the opposite order. The step to each next group is gated on a measured voltage and not on a fixed delay. Each group has a sampled voltage code and a nominal code. From the nominal code the block derives three limits:

- a "reached" limit at nine tenths of nominal;
- a "discharged" limit at one tenth of nominal;
- an over-voltage limit at eleven tenths of nominal.

A group is enabled only after the group below it has reached its limit. A group is disabled only after the group above it has discharged.

A free-running microsecond tick times each sequence. The power-up has a window with a minimum and a maximum, and the power-down has a maximum. Once all three groups are up, the block watches them continuously. A reading outside the window latches a per-group under-voltage or over-voltage flag and starts an orderly power-down that ends in a fault state.

A power-up that runs too long, or a shutdown request that arrives mid-ramp, also ends in a power-down. That power-down starts from the highest group that is enabled. A fault is cleared only by a new start request.

Top module: `rail_seq`

## Requirements
- R1: After reset, `seq_state` is 0, `rail_en` is 0, and `ready` and all fault flags are 0. The state codes are: IDLE=0, UP1=1, UP2=2, UP3=3, ON=4, DN3=5, DN2=6, DN1=7, FAULT=8.
- R2: Bit 0 of `rail_en` drives group 1, bit 1 drives group 2 and bit 2 drives group 3. A start request enables group 1 alone. Group k+1 is enabled only once group k's reading is at or above its reached limit, giving 001, then 011, then 111.
- R3: Power-down disables group 3 first, then group 2, then group 1 (`rail_en` 011, then 001, then 000). Each step waits for the group just disabled to read at or below its discharged limit.
- R4: For a nominal code N, the limits are computed in integer arithmetic with truncation: reached is (N*9)/10, discharged is N/10, and over-voltage is (N*11)/10.
- R5: `ready` is high only in ON, and only once at least MIN_UP_US ticks have passed since the start request was taken.
- R6: If power-up is still incomplete MAX_UP_US ticks after the start, `up_timeout` is set and power-down begins from the highest enabled group. The sequence then ends in FAULT.
- R7: If a power-down has not finished MAX_DN_US ticks after it began, `dn_timeout` is set, all enables drop at once, and the state goes to FAULT.
- R8: A shutdown request during UP1, UP2 or UP3 goes to DN1, DN2 or DN3 respectively. When no fault is pending, the sequence ends in IDLE.
- R9: In ON, a reading below the reached limit sets that group's bit in `uv_flag`. A reading strictly above the over-voltage limit sets that group's bit in `ov_flag`. Either one starts power-down at DN3, and the sequence ends in FAULT.
- R10: In FAULT all enables are 0. A start request clears every fault flag and begins a new power-up at UP1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start_req | input | 1 | Request to power up |
| stop_req | input | 1 | Request to power down |
| meas_g1 | input | W | Sampled voltage code, group 1 |
| meas_g2 | input | W | Sampled voltage code, group 2 |
| meas_g3 | input | W | Sampled voltage code, group 3 |
| nom_g1 | input | W | Nominal voltage code, group 1 |
| nom_g2 | input | W | Nominal voltage code, group 2 |
| nom_g3 | input | W | Nominal voltage code, group 3 |
| rail_en | output | 3 | Per-group enable, bit 0 is group 1 |
| ready | output | 1 | All groups up and minimum window elapsed |
| seq_state | output | 4 | Current sequencer state code |
| up_timeout | output | 1 | Power-up exceeded its maximum |
| dn_timeout | output | 1 | Power-down exceeded its maximum |
| uv_flag | output | 3 | Latched under-voltage per group |
| ov_flag | output | 3 | Latched over-voltage per group |

## Verification
The bench builds the block with MIN_UP_US=20, MAX_UP_US=100 and MAX_DN_US=100, and holds `us_tick` high on every cycle. With these values the minimum-ready window, both timeouts and the cycle just before each limit can be reached within a few hundred cycles. Group 1 uses the nominal code 1234, whose limits truncate (1110, 123, 1357). This exposes the exact rounding of the limits at the gating boundary.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int W         = 12,
  parameter int MIN_UP_US = 200,
  parameter int MAX_UP_US = 100000,
  parameter int MAX_DN_US = 100000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         us_tick,
  input  logic         start_req,
  input  logic         stop_req,
  input  logic [W-1:0] meas_g1,
  input  logic [W-1:0] meas_g2,
  input  logic [W-1:0] meas_g3,
  input  logic [W-1:0] nom_g1,
  input  logic [W-1:0] nom_g2,
  input  logic [W-1:0] nom_g3,
  output logic [2:0]   rail_en,
  output logic         ready,
  output logic [3:0]   seq_state,
  output logic         up_timeout,
  output logic         dn_timeout,
  output logic [2:0]   uv_flag,
  output logic [2:0]   ov_flag
);

  localparam int XW   = W + 4;
  localparam int TMAX = (MAX_UP_US > MAX_DN_US) ? MAX_UP_US : MAX_DN_US;
  localparam int CW   = $clog2(TMAX + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0, S_UP1 = 4'd1, S_UP2 = 4'd2, S_UP3 = 4'd3,
    S_ON    = 4'd4, S_DN3 = 4'd5, S_DN2 = 4'd6, S_DN1 = 4'd7,
    S_FAULT = 4'd8
  } seq_t;

  seq_t st, nxt;
  logic [CW-1:0] cnt;
  logic clr, set_upto, set_dnto, set_mon, clr_flags;

  logic [W-1:0] meas [3];
  logic [W-1:0] nom  [3];
  logic [W-1:0] hi   [3];
  logic [W-1:0] lo   [3];
  logic [XW-1:0] ovt [3];
  logic [2:0] reached, drained, low_now, high_now;

  assign meas[0] = meas_g1;
  assign meas[1] = meas_g2;
  assign meas[2] = meas_g3;
  assign nom[0]  = nom_g1;
  assign nom[1]  = nom_g2;
  assign nom[2]  = nom_g3;

  for (genvar g = 0; g < 3; g++) begin : g_lim
    logic [XW-1:0] x9;
    assign x9          = (XW'(nom[g]) * XW'(9)) / XW'(10);
    assign hi[g]       = W'(x9);
    assign lo[g]       = nom[g] / W'(10);
    assign ovt[g]      = (XW'(nom[g]) * XW'(11)) / XW'(10);
    assign reached[g]  = meas[g] >= hi[g];
    assign drained[g]  = meas[g] <= lo[g];
    assign low_now[g]  = meas[g] < hi[g];
    assign high_now[g] = XW'(meas[g]) > ovt[g];
  end

  wire up_late = cnt >= CW'(MAX_UP_US);
  wire dn_late = cnt >= CW'(MAX_DN_US);
  wire faulted = up_timeout | (|uv_flag) | (|ov_flag);
  wire go      = start_req & ~stop_req;

  always_comb begin
    nxt = st; clr = 1'b0; set_upto = 1'b0; set_dnto = 1'b0;
    set_mon = 1'b0; clr_flags = 1'b0;
    case (st)
      S_IDLE:  if (go) begin nxt = S_UP1; clr = 1'b1; end
      S_FAULT: if (go) begin nxt = S_UP1; clr = 1'b1; clr_flags = 1'b1; end
      S_UP1: begin
        if (stop_req) begin nxt = S_DN1; clr = 1'b1; end
        else if (up_late) begin nxt = S_DN1; clr = 1'b1; set_upto = 1'b1; end
        else if (reached[0]) nxt = S_UP2;
      end
      S_UP2: begin
        if (stop_req) begin nxt = S_DN2; clr = 1'b1; end
        else if (up_late) begin nxt = S_DN2; clr = 1'b1; set_upto = 1'b1; end
        else if (reached[1]) nxt = S_UP3;
      end
      S_UP3: begin
        if (stop_req) begin nxt = S_DN3; clr = 1'b1; end
        else if (up_late) begin nxt = S_DN3; clr = 1'b1; set_upto = 1'b1; end
        else if (reached[2]) nxt = S_ON;
      end
      S_ON: begin
        if (|(low_now | high_now)) begin nxt = S_DN3; clr = 1'b1; set_mon = 1'b1; end
        else if (stop_req) begin nxt = S_DN3; clr = 1'b1; end
      end
      S_DN3: begin
        if (dn_late) begin nxt = S_FAULT; set_dnto = 1'b1; end
        else if (drained[2]) nxt = S_DN2;
      end
      S_DN2: begin
        if (dn_late) begin nxt = S_FAULT; set_dnto = 1'b1; end
        else if (drained[1]) nxt = S_DN1;
      end
      S_DN1: begin
        if (dn_late) begin nxt = S_FAULT; set_dnto = 1'b1; end
        else if (drained[0]) nxt = faulted ? S_FAULT : S_IDLE;
      end
      default: nxt = S_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      up_timeout <= 1'b0;
      dn_timeout <= 1'b0;
      uv_flag <= '0;
      ov_flag <= '0;
    end else begin
      st <= nxt;
      if (clr) cnt <= '0;
      else if (us_tick && !(&cnt)) cnt <= cnt + 1'b1;
      if (clr_flags) begin
        up_timeout <= 1'b0;
        dn_timeout <= 1'b0;
        uv_flag <= '0;
        ov_flag <= '0;
      end else begin
        if (set_upto) up_timeout <= 1'b1;
        if (set_dnto) dn_timeout <= 1'b1;
        if (set_mon) begin
          uv_flag <= uv_flag | low_now;
          ov_flag <= ov_flag | high_now;
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_UP1, S_DN2:        rail_en = 3'b001;
      S_UP2, S_DN3:        rail_en = 3'b011;
      S_UP3, S_ON:         rail_en = 3'b111;
      default:             rail_en = 3'b000;
    endcase
  end

  assign ready     = (st == S_ON) && (cnt >= CW'(MIN_UP_US));
  assign seq_state = st;

  // R2
  g2_after_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> $past(meas_g1 >= hi[0]));
  // R2
  g3_after_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[2]) |-> $past(meas_g2 >= hi[1]));
  // R3
  g1_off_after_g2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[0]) && !dn_timeout |-> $past(meas_g2 <= lo[1]) || $past(st == S_UP1));
  // R5
  ready_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> seq_state == 4'd4);
  // R6
  up_to_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_timeout) |-> $past(st == S_UP1 || st == S_UP2 || st == S_UP3));
  // R10
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FAULT |-> rail_en == 3'b000);

endmodule

// File: tb/sim_rail_seq.sv
module sim_rail_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0;
  logic [11:0] m1 = '0, m2 = '0, m3 = '0;
  logic [11:0] n1 = 12'd1234, n2 = 12'd1000, n3 = 12'd1000;
  logic [2:0] rail_en, uv_flag, ov_flag;
  logic ready, up_timeout, dn_timeout;
  logic [3:0] seq_state;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rail_seq #(.W(12), .MIN_UP_US(20), .MAX_UP_US(100), .MAX_DN_US(100)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(1'b1), .start_req(start_req),
    .stop_req(stop_req), .meas_g1(m1), .meas_g2(m2), .meas_g3(m3),
    .nom_g1(n1), .nom_g2(n2), .nom_g3(n3), .rail_en(rail_en), .ready(ready),
    .seq_state(seq_state), .up_timeout(up_timeout), .dn_timeout(dn_timeout),
    .uv_flag(uv_flag), .ov_flag(ov_flag));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 state", seq_state, 0);
    chk("R1 enables", rail_en, 0);
    chk("R1 ready", ready, 0);
    chk("R1 flags", {up_timeout, dn_timeout, uv_flag, ov_flag}, 0);
  endtask

  task automatic t_ramp;
    start_req = 1'b1; step(2); start_req = 1'b0;
    chk("R2 UP1 state", seq_state, 1);
    chk("R2 UP1 enables", rail_en, 3'b001);
    m1 = 12'd1109; step(3);
    chk("R4 reached limit 1110 not met", seq_state, 1);
    m1 = 12'd1110; step(2);
    chk("R2 R4 UP2 state", seq_state, 2);
    chk("R2 UP2 enables", rail_en, 3'b011);
    m2 = 12'd1000; step(2);
    chk("R2 UP3 enables", rail_en, 3'b111);
    m3 = 12'd950; step(2);
    chk("R2 ON state", seq_state, 4);
    chk("R5 ready held low early", ready, 0);
    step(30);
    chk("R5 ready after window", ready, 1);
  endtask

  task automatic t_monitor;
    m2 = 12'd1100; step(3);
    chk("R9 at over-voltage limit stays ON", seq_state, 4);
    chk("R9 no ov flag at limit", ov_flag, 0);
    m2 = 12'd1101; step(2);
    chk("R9 ov starts DN3", seq_state, 5);
    chk("R9 ov flag group 2", ov_flag, 3'b010);
    chk("R3 DN3 enables", rail_en, 3'b011);
    m3 = 12'd100; step(2);
    chk("R3 DN2 state", seq_state, 6);
    chk("R3 DN2 enables", rail_en, 3'b001);
    m2 = 12'd101; step(3);
    chk("R3 waits for discharge", seq_state, 6);
    m2 = 12'd100; step(2);
    chk("R3 DN1 state", seq_state, 7);
    m1 = 12'd124; step(3);
    chk("R4 discharged limit 123 not met", seq_state, 7);
    m1 = 12'd123; step(2);
    chk("R9 ends in FAULT", seq_state, 8);
    chk("R10 FAULT enables", rail_en, 0);
  endtask

  task automatic t_up_timeout;
    m1 = 0; m2 = 0; m3 = 0;
    start_req = 1'b1; step(2); start_req = 1'b0;
    chk("R10 restart UP1", seq_state, 1);
    chk("R10 flags cleared", ov_flag, 0);
    step(90);
    chk("R6 still ramping before limit", seq_state, 1);
    step(20);
    chk("R6 timeout flag", up_timeout, 1);
    chk("R6 ends FAULT", seq_state, 8);
    chk("R6 enables off", rail_en, 0);
  endtask

  task automatic t_abort;
    m1 = 12'd1234;
    start_req = 1'b1; step(1); start_req = 1'b0; step(2);
    chk("R8 in UP2", seq_state, 2);
    chk("R10 up_timeout cleared", up_timeout, 0);
    m1 = 12'd1234; stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R8 abort to DN2", seq_state, 6);
    chk("R8 DN2 enables", rail_en, 3'b001);
    step(2);
    chk("R8 DN1 holds while g1 high", seq_state, 7);
    m1 = 0; step(2);
    chk("R8 ends IDLE", seq_state, 0);
  endtask

  task automatic t_dn_timeout;
    m1 = 12'd1234; m2 = 12'd1000; m3 = 12'd1000;
    start_req = 1'b1; step(1); start_req = 1'b0; step(4);
    chk("R2 ON again", seq_state, 4);
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R3 stop to DN3", seq_state, 5);
    step(90);
    chk("R7 still DN3 before limit", seq_state, 5);
    step(20);
    chk("R7 FAULT", seq_state, 8);
    chk("R7 flag", dn_timeout, 1);
    chk("R7 enables off", rail_en, 0);
  endtask

  task automatic t_clean_down;
    start_req = 1'b1; step(1); start_req = 1'b0; step(4);
    chk("R10 ON from FAULT", seq_state, 4);
    chk("R10 dn_timeout cleared", dn_timeout, 0);
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    m3 = 0; step(2);
    chk("R3 DN2 after g3 drained", seq_state, 6);
    m2 = 0; step(2);
    chk("R3 DN1 after g2 drained", seq_state, 7);
    m1 = 0; step(2);
    chk("R3 clean end IDLE", seq_state, 0);
    chk("R3 no flags", {up_timeout, dn_timeout, uv_flag, ov_flag}, 0);
  endtask

  task automatic t_uv;
    m1 = 12'd1234; m2 = 12'd1000; m3 = 12'd1000;
    start_req = 1'b1; step(1); start_req = 1'b0; step(4);
    m3 = 12'd899; step(2);
    chk("R9 uv starts DN3", seq_state, 5);
    chk("R9 uv flag group 3", uv_flag, 3'b100);
    m1 = 0; m2 = 0; m3 = 0; step(4);
    chk("R9 uv ends FAULT", seq_state, 8);
  endtask

  task automatic run_all;
    step(3); rst_n = 1'b1; step(1);
    t_reset; t_ramp; t_monitor; t_up_timeout; t_abort;
    t_dn_timeout; t_clean_down; t_uv;
  endtask

  initial begin
    fork
      run_all;
      begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule